// File: doc/BRIEF.md
# Isolated-Launch Sequencer

This controller moves a processing core into isolation mode through a fixed hardware sequence that software cannot shorten or reorder. An isolation request first halts whatever thread the core is running and waits for the core to confirm it has stopped. The controller then reads the application image word by word from external memory through a simple read-request interface and writes each word into the core's protected local memory. Next it starts an external integrity-check engine, and after that a root-key decryption engine. The decryption engine's writes reach local memory only through this block.

The core is released to execute in isolation only when both engines report success. If either engine reports failure, the block wipes every local memory word to zero and records a status code naming the failing stage. It then returns to the non-isolated idle state and never releases the core. The decryption engine receives only a one-bit enable, and that enable is high only during the decrypt stage, which always lies inside isolation mode. A running isolated application can be relaunched any number of times.

Top module: `iso_launch_ctrl`

## Requirements
- R1: After reset the block is idle. core_run_o, core_halt_o, key_en_o, iso_o and rd_req_o are 0, and fail_code_o is 0.
- R2: A request accepted on iso_req_i sets core_halt_o and iso_o in the next cycle and clears core_run_o. core_halt_o stays high until core_stopped_i is seen.
- R3: The image is copied in order. Word i (0 to IMG_WORDS-1) is read from address img_base_i+i, and its data is written unchanged to local address i.
- R4: vfy_start_o pulses for exactly one cycle, directly after the last image word is written, and never before all IMG_WORDS words are in local memory.
- R5: After a passing check, key_en_o is 1 and dec_start_o pulses. Each dec_we_i beat is written to local memory at dec_addr_i with dec_wdata_i.
- R6: key_en_o is 1 only in the decrypt stage, never while the core runs and never outside isolation. A dec_we_i beat outside the decrypt stage (for example while idle) produces no local memory write.
- R7: core_run_o rises only after dec_done_i arrives with dec_pass_i=1, and iso_o stays 1 while running.
- R8: A failing check or failing decrypt never raises core_run_o. The block writes zero to all LM_DEPTH local addresses, from 0 upward, and sets fail_code_o to 1 (check failed) or 2 (decrypt failed). It then returns to idle with iso_o=0.
- R9: iso_req_i is ignored while halting, fetching, checking, decrypting or wiping. The write sequence and the outcome are those of the launch already in progress.
- R10: A launch may be repeated any number of times, from idle or from the running state. Each accepted request clears fail_code_o to 0 and repeats the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_req_i | input | 1 | Isolation launch request |
| core_stopped_i | input | 1 | Core confirms its thread is stopped |
| core_halt_o | output | 1 | Halt/cancel command to the core |
| core_run_o | output | 1 | Core released to run in isolation |
| iso_o | output | 1 | Isolation mode active |
| img_base_i | input | AW | External address of the image |
| rd_req_o | output | 1 | Read request, held until rd_valid_i |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid; completes the request |
| rd_data_i | input | DW | Read data |
| lm_we_o | output | 1 | Local memory write enable |
| lm_addr_o | output | LW | Local memory word address |
| lm_wdata_o | output | DW | Local memory write data |
| vfy_start_o | output | 1 | Integrity check start pulse |
| vfy_done_i | input | 1 | Integrity check done |
| vfy_pass_i | input | 1 | Integrity check result, valid with done |
| dec_start_o | output | 1 | Decrypt start pulse |
| dec_done_i | input | 1 | Decrypt done |
| dec_pass_i | input | 1 | Decrypt result, valid with done |
| key_en_o | output | 1 | Root-key enable to the decrypt engine |
| dec_we_i | input | 1 | Decrypt engine write strobe |
| dec_addr_i | input | LW | Decrypt engine write address |
| dec_wdata_i | input | DW | Decrypt engine write data |
| fail_code_o | output | 2 | 0 none, 1 check failed, 2 decrypt failed |

## Verification
The assertions assume a well-behaved environment. The core raises core_stopped_i only in answer to core_halt_o. The memory side asserts rd_valid_i only while rd_req_o is high. The engines give done only after their own start pulse. The bench's models follow exactly these rules: the core model echoes the halt one cycle late, the memory model answers each held request one cycle later, and the engine models count from the observed start pulse. The only deliberately out-of-place stimulus is requests during busy stages and a decrypt write while idle. Those are the cases R6 and R9 say must have no effect.

// File: rtl/iso_launch_pkg.sv
package iso_launch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CANCEL, ST_FETCH, ST_VERIFY, ST_DECRYPT, ST_RUN, ST_FAIL
  } iso_st_e;

  localparam logic [1:0] FC_NONE    = 2'd0;
  localparam logic [1:0] FC_VERIFY  = 2'd1;
  localparam logic [1:0] FC_DECRYPT = 2'd2;

  // a launch request is only honoured from these two states
  function automatic logic accepts_req(iso_st_e s);
    return (s == ST_IDLE) || (s == ST_RUN);
  endfunction

  // states in which a new request must leave no trace
  function automatic logic is_busy(iso_st_e s);
    return (s == ST_FETCH) || (s == ST_VERIFY) || (s == ST_DECRYPT) || (s == ST_FAIL);
  endfunction

endpackage

// File: rtl/iso_launch_fsm.sv
module iso_launch_fsm
  import iso_launch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iso_req_i,
  input  logic       core_stopped_i,
  input  logic       fetch_last_i,
  input  logic       erase_last_i,
  input  logic       vfy_done_i,
  input  logic       vfy_pass_i,
  input  logic       dec_done_i,
  input  logic       dec_pass_i,
  output iso_st_e    st_o,
  output logic       first_o,
  output logic [1:0] fail_code_o
);
  iso_st_e    st_q, st_d, prev_q;
  logic [1:0] code_q, code_d;

  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    case (st_q)
      ST_IDLE, ST_RUN: if (iso_req_i && accepts_req(st_q)) begin
        st_d   = ST_CANCEL;
        code_d = FC_NONE;
      end
      ST_CANCEL:  if (core_stopped_i) st_d = ST_FETCH;
      ST_FETCH:   if (fetch_last_i)   st_d = ST_VERIFY;
      ST_VERIFY:  if (vfy_done_i) begin
        if (vfy_pass_i) st_d = ST_DECRYPT;
        else begin st_d = ST_FAIL; code_d = FC_VERIFY; end
      end
      ST_DECRYPT: if (dec_done_i) begin
        if (dec_pass_i) st_d = ST_RUN;
        else begin st_d = ST_FAIL; code_d = FC_DECRYPT; end
      end
      ST_FAIL:    if (erase_last_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prev_q <= ST_IDLE;
      code_q <= FC_NONE;
    end else begin
      st_q   <= st_d;
      prev_q <= st_q;
      code_q <= code_d;
    end
  end

  assign st_o        = st_q;
  assign first_o     = (st_q != prev_q);
  assign fail_code_o = code_q;

  // R8: a failure code is only ever recorded by leaving a check stage
  a_r8_code_from_check: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != FC_NONE && $past(code_q) == FC_NONE) |-> $past(st_q == ST_VERIFY || st_q == ST_DECRYPT));
  // R2: cancel is left only once the core confirmed it stopped
  a_r2_cancel_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_CANCEL && st_q == ST_FETCH) |-> $past(core_stopped_i));
endmodule

// File: rtl/iso_lm_port.sv
module iso_lm_port
  import iso_launch_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LM_DEPTH  = 16,
  parameter int IMG_WORDS = 8,
  localparam int LW       = $clog2(LM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  iso_st_e       st_i,
  input  logic [AW-1:0] img_base_i,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          dec_we_i,
  input  logic [LW-1:0] dec_addr_i,
  input  logic [DW-1:0] dec_wdata_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          lm_we_o,
  output logic [LW-1:0] lm_addr_o,
  output logic [DW-1:0] lm_wdata_o,
  output logic          fetch_last_o,
  output logic          erase_last_o
);
  logic [LW-1:0] cnt_q;
  logic fetch_beat, dec_beat, erase_beat, counting;

  assign counting   = (st_i == ST_FETCH) || (st_i == ST_FAIL);
  assign fetch_beat = (st_i == ST_FETCH) && rd_valid_i;
  assign dec_beat   = (st_i == ST_DECRYPT) && dec_we_i;
  assign erase_beat = (st_i == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!counting)                cnt_q <= '0;
    else if (fetch_beat || erase_beat) cnt_q <= cnt_q + 1'b1;
  end

  assign rd_req_o     = (st_i == ST_FETCH);
  assign rd_addr_o    = img_base_i + AW'(cnt_q);
  assign fetch_last_o = fetch_beat && (cnt_q == LW'(IMG_WORDS - 1));
  assign erase_last_o = erase_beat && (cnt_q == LW'(LM_DEPTH - 1));

  assign lm_we_o    = fetch_beat || dec_beat || erase_beat;
  assign lm_addr_o  = dec_beat ? dec_addr_i : cnt_q;
  assign lm_wdata_o = fetch_beat ? rd_data_i : (dec_beat ? dec_wdata_i : '0);

  // R6: decrypt strobes outside the decrypt stage never reach local memory
  a_r6_dec_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_we_i && !rd_valid_i && st_i != ST_DECRYPT && st_i != ST_FAIL) |-> !lm_we_o);
  // R8: every wipe cycle writes zero
  a_r8_wipe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == ST_FAIL) |-> (lm_we_o && lm_wdata_o == '0));
  // R3: consecutive image reads step the address by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fetch_beat) && !$past(fetch_last_o) && st_i == ST_FETCH) |-> (rd_addr_o == $past(rd_addr_o) + AW'(1)));
endmodule

// File: rtl/iso_launch_ctrl.sv
module iso_launch_ctrl
  import iso_launch_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LM_DEPTH  = 16,
  parameter int IMG_WORDS = 8,
  localparam int LW       = $clog2(LM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iso_req_i,
  input  logic          core_stopped_i,
  output logic          core_halt_o,
  output logic          core_run_o,
  output logic          iso_o,
  input  logic [AW-1:0] img_base_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          lm_we_o,
  output logic [LW-1:0] lm_addr_o,
  output logic [DW-1:0] lm_wdata_o,
  output logic          vfy_start_o,
  input  logic          vfy_done_i,
  input  logic          vfy_pass_i,
  output logic          dec_start_o,
  input  logic          dec_done_i,
  input  logic          dec_pass_i,
  output logic          key_en_o,
  input  logic          dec_we_i,
  input  logic [LW-1:0] dec_addr_i,
  input  logic [DW-1:0] dec_wdata_i,
  output logic [1:0]    fail_code_o
);
  iso_st_e st;
  logic    st_first, fetch_last, erase_last;

  iso_launch_fsm u_fsm (
    .clk, .rst_n, .iso_req_i, .core_stopped_i,
    .fetch_last_i (fetch_last),
    .erase_last_i (erase_last),
    .vfy_done_i, .vfy_pass_i, .dec_done_i, .dec_pass_i,
    .st_o         (st),
    .first_o      (st_first),
    .fail_code_o
  );

  iso_lm_port #(.AW(AW), .DW(DW), .LM_DEPTH(LM_DEPTH), .IMG_WORDS(IMG_WORDS)) u_lm (
    .clk, .rst_n,
    .st_i         (st),
    .img_base_i, .rd_valid_i, .rd_data_i, .dec_we_i, .dec_addr_i, .dec_wdata_i,
    .rd_req_o, .rd_addr_o, .lm_we_o, .lm_addr_o, .lm_wdata_o,
    .fetch_last_o (fetch_last),
    .erase_last_o (erase_last)
  );

  assign core_halt_o = (st == ST_CANCEL);
  assign core_run_o  = (st == ST_RUN);
  assign iso_o       = (st != ST_IDLE);
  assign key_en_o    = (st == ST_DECRYPT);
  assign vfy_start_o = (st == ST_VERIFY)  && st_first;
  assign dec_start_o = (st == ST_DECRYPT) && st_first;

  // R6: the root-key enable lives strictly inside isolation, never with the core running
  a_r6_key_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    key_en_o |-> (iso_o && !core_run_o && !core_halt_o));
  // R7: release only follows a passing decrypt
  a_r7_run_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run_o) |-> $past(dec_done_i && dec_pass_i && key_en_o));
  // R8: a recorded failure excludes running
  a_r8_fail_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_code_o != FC_NONE) |-> !core_run_o);
  // R4: the check starts right after the last image word was taken
  a_r4_vfy_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_start_o |-> $past(rd_req_o && rd_valid_i));
  // R2: halting and running never overlap
  a_r2_halt_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt_o |-> !core_run_o);
  // R9: a request in a busy stage does not start a cancel
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_req_i && is_busy(st)) |=> !core_halt_o);
endmodule

// File: tb/sim_iso_launch_ctrl.sv
`timescale 1ns/1ps
module sim_iso_launch_ctrl;
  localparam int AW = 32, DW = 32, LM_DEPTH = 16, IMG_WORDS = 8;
  localparam int LW = $clog2(LM_DEPTH);

  logic clk = 0;
  logic rst_n = 0;
  logic iso_req_i = 0, core_stopped_i = 0;
  logic [AW-1:0] img_base_i = '0;
  logic rd_valid_i = 0;
  logic [DW-1:0] rd_data_i = '0;
  logic vfy_done_i = 0, vfy_pass_i = 0, dec_done_i = 0, dec_pass_i = 0;
  logic dec_we_i = 0;
  logic [LW-1:0] dec_addr_i = '0;
  logic [DW-1:0] dec_wdata_i = '0;
  logic core_halt_o, core_run_o, iso_o, rd_req_o, lm_we_o, vfy_start_o, dec_start_o, key_en_o;
  logic [AW-1:0] rd_addr_o;
  logic [LW-1:0] lm_addr_o;
  logic [DW-1:0] lm_wdata_o;
  logic [1:0] fail_code_o;

  always #2.5 clk = ~clk;

  iso_launch_ctrl #(.AW(AW), .DW(DW), .LM_DEPTH(LM_DEPTH), .IMG_WORDS(IMG_WORDS)) u0 (.*);

  typedef struct { logic [31:0] addr; logic [31:0] data; int kind; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, fetch_seen = 0;
  bit vfy_result = 1, dec_result = 1, stray_req = 0;
  logic [AW-1:0] cur_base = '0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] dec_word(logic [31:0] b, int k);
    return {b[15:0], 16'hD0D0} + 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // external memory: answer each held request one cycle later
  always @(negedge clk) begin
    rd_valid_i <= rd_req_o && !rd_valid_i;
    rd_data_i  <= mem_word(rd_addr_o);
  end
  // core: confirms the halt one cycle after it sees it
  always @(negedge clk) core_stopped_i <= core_halt_o;

  // integrity engine model
  int vcnt = 0;
  always @(negedge clk) begin
    vfy_done_i = 0;
    if (vcnt > 0) begin
      vcnt--;
      if (vcnt == 0) begin vfy_done_i = 1; vfy_pass_i = vfy_result; end
    end else if (vfy_start_o) vcnt = 2;
  end

  // decrypt engine model: two writes then done; also injects the stray idle write
  int dstep = 0;
  always @(negedge clk) begin
    dec_we_i = 0; dec_done_i = 0;
    if (stray_req) begin
      dec_we_i = 1; dec_addr_i = LW'(3); dec_wdata_i = 32'hBAD0_0001;
    end else if (dstep == 0 && dec_start_o) begin
      dstep = 1; dec_we_i = 1; dec_addr_i = LW'(2); dec_wdata_i = dec_word(cur_base, 0);
    end else if (dstep == 1) dstep = 2;
    else if (dstep == 2) begin
      dstep = 3; dec_we_i = 1; dec_addr_i = LW'(5); dec_wdata_i = dec_word(cur_base, 1);
    end else if (dstep == 3) begin
      dstep = 0; dec_done_i = 1; dec_pass_i = dec_result;
    end
  end

  // monitor: scoreboard of local memory writes plus stage checks
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (lm_we_o) begin
        if (exp_q.size() == 0)
          chk(0, "R6", "unexpected local write", {28'b0, lm_addr_o, lm_wdata_o}, 64'h0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk({28'b0, lm_addr_o} == it.addr && lm_wdata_o == it.data,
              it.kind == 0 ? "R3" : (it.kind == 1 ? "R5" : "R8"), "local write",
              {28'b0, lm_addr_o, lm_wdata_o}, {it.addr, it.data});
          if (it.kind == 0) fetch_seen++;
        end
      end
      if (vfy_start_o) chk(fetch_seen == IMG_WORDS, "R4", "check started early", 64'(fetch_seen), 64'(IMG_WORDS));
      if (dec_we_i && !stray_req) chk(key_en_o, "R5", "key enable during decrypt", 64'(key_en_o), 64'h1);
      if (key_en_o) chk(iso_o && !core_run_o, "R6", "key enable outside decrypt", {62'b0, iso_o, core_run_o}, 64'h2);
    end
  end

  task automatic launch(input bit vp, input bit dp, input logic [AW-1:0] base, input bit poke);
    int guard;
    cur_base = base; img_base_i = base; vfy_result = vp; dec_result = dp; fetch_seen = 0;
    for (int i = 0; i < IMG_WORDS; i++) exp_q.push_back('{32'(i), mem_word(base + 32'(i)), 0});
    if (vp) begin
      exp_q.push_back('{32'd2, dec_word(base, 0), 1});
      exp_q.push_back('{32'd5, dec_word(base, 1), 1});
    end
    if (!vp || !dp)
      for (int i = 0; i < LM_DEPTH; i++) exp_q.push_back('{32'(i), 32'h0, 2});
    @(negedge clk); iso_req_i = 1;
    @(negedge clk); iso_req_i = 0; #1;
    chk(core_halt_o && !core_run_o && iso_o, "R2", "halt after request", {61'b0, core_halt_o, core_run_o, iso_o}, 64'h5);
    chk(fail_code_o == 2'd0, "R10", "code cleared by request", 64'(fail_code_o), 64'h0);
    if (poke) begin
      guard = 0;
      while (!rd_req_o && guard < 50) begin @(negedge clk); #1; guard++; end
      @(negedge clk); iso_req_i = 1;
      @(negedge clk); iso_req_i = 0; #1;
      chk(!core_halt_o && rd_req_o, "R9", "request during fetch ignored", {62'b0, core_halt_o, rd_req_o}, 64'h1);
    end
    guard = 0;
    while (!core_run_o && iso_o && guard < 500) begin @(negedge clk); #1; guard++; end
    if (vp && dp) begin
      chk(core_run_o && iso_o && fail_code_o == 0, "R7", "released after passing launch",
          {60'b0, core_run_o, iso_o, fail_code_o}, 64'hC);
    end else begin
      chk(!core_run_o && !iso_o, "R8", "back to idle after failure", {62'b0, core_run_o, iso_o}, 64'h0);
      chk(fail_code_o == (vp ? 2'd2 : 2'd1), "R8", "failure code", 64'(fail_code_o), vp ? 64'h2 : 64'h1);
    end
    chk(exp_q.size() == 0 && !key_en_o, "R3", "all expected writes seen", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!core_run_o && !core_halt_o && !key_en_o && !iso_o && !rd_req_o && fail_code_o == 0, "R1", "reset outputs",
        {58'b0, core_run_o, core_halt_o, key_en_o, iso_o, rd_req_o, lm_we_o}, 64'h0);
    // R6: decrypt strobe while idle must not write
    @(negedge clk); stray_req = 1; #1;
    chk(!lm_we_o && !key_en_o, "R6", "idle decrypt strobe ignored", {62'b0, lm_we_o, key_en_o}, 64'h0);
    @(negedge clk); stray_req = 0;
    launch(1, 1, 32'h0000_1000, 0);   // R7 first launch
    launch(1, 1, 32'h0000_2000, 0);   // R10 relaunch from running
    launch(0, 1, 32'h0000_3000, 0);   // R8 check failure from running
    launch(1, 0, 32'h0000_4000, 0);   // R8 decrypt failure from idle
    launch(1, 1, 32'h0000_5000, 1);   // R9 busy request, R10 code cleared
    repeat (4) @(negedge clk);
    #1 chk(core_run_o && !key_en_o, "R6", "running without key enable", {62'b0, core_run_o, key_en_o}, 64'h2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule